// File: doc/BRIEF.md
# Masked Interrupt Event Register

This block collects interrupt events from hardware sources into one event register of 88 bits (eleven bytes). It drives a single active-low interrupt pin. Each source raises a one-cycle set request on its own bit. A mask register, loaded by the host, decides whether that bit may become set at all. The mask acts before the event is stored, not on the pin. So a masked event is never recorded and cannot appear later when the mask is opened.

The host reaches the registers one byte at a time through a plain register port. The port has a write strobe, an address and data in, and combinational read data. The event register is read-only. The host removes events by writing ones into a separate clear register. That register holds no state. Each write to it becomes a one-cycle clear pulse on the matching event bits, and it always reads back as zero. The pin is low for as long as any event bit is one.

Top module: `masked_irq_event`

## Requirements
- R1: After reset, every event bit is 0, every mask bit is 1, and `irq_n` is 1.
- R2: `irq_n` is 0 exactly while at least one event bit is 1.
- R3: A set request on bit b sets event bit b at the next clock edge when mask bit b is 1. When mask bit b is 0, event bit b stays unchanged.
- R4: A host write to the clear register clears, at that clock edge, each event bit of the addressed byte whose data bit is 1. Every other event bit keeps its value.
- R5: If a bit gets an allowed set request in the same cycle as a clear of that bit, the bit ends up set.
- R6: Writing a mask bit to 0 leaves an event bit that is already set unchanged.
- R7: Host writes to the event register have no effect.
- R8: The clear register reads back as 0x00 at every byte.
- R9: A host write to a mask byte replaces that byte at the clock edge and leaves every other mask byte unchanged. The new mask applies from the following cycle on.
- R10: The address is {select[1:0], byte index[3:0]}. Select 0 is event, 1 is mask, 2 is clear and 3 is unused. Byte index k covers bits 8k+7..8k. A byte index of 11 or more, or select 3, reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set | input | 88 | Per-bit event set requests from hardware |
| host_wr | input | 1 | Host write strobe, one cycle per byte write |
| host_addr | input | 6 | {register select, byte index} |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Combinational read data of the addressed byte |
| irq_n | output | 1 | Active-low interrupt, low while any event is set |

## Verification
A hardware set request and a host clear can hit the same event bit in the same cycle. So can a set request and a mask write to the same byte. The bench drives a set request on all bits while it writes a full clear byte, and it drives set requests into a byte that is being masked in that same cycle. It then reads every byte of every register at the next falling edge. The result is compared with a model in which the set wins over the clear and a mask write takes effect one cycle later.

// File: rtl/mie_pkg.sv
`timescale 1ns/1ps
package mie_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_EVENT = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_CLEAR = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mie_host_port.sv
`timescale 1ns/1ps
module mie_host_port
  import mie_pkg::*;
#(
  parameter int NUM_BYTES = 11,
  parameter int IDX_W     = $clog2(NUM_BYTES),
  parameter int WIDTH     = NUM_BYTES * 8
) (
  input  logic                     host_wr,
  input  logic [SEL_W+IDX_W-1:0]   host_addr,
  input  logic [7:0]               host_wdata,
  input  logic [WIDTH-1:0]         event_q,
  input  logic [WIDTH-1:0]         mask_q,
  output logic [NUM_BYTES-1:0]     mask_lane_we,
  output logic [WIDTH-1:0]         clr_vec,
  output logic [7:0]               host_rdata
);
  reg_sel_e         sel;
  logic [IDX_W-1:0] idx;

  assign sel = reg_sel_e'(host_addr[SEL_W+IDX_W-1:IDX_W]);
  assign idx = host_addr[IDX_W-1:0];

  // per-lane write decode; out-of-range indices match no lane
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    logic lane_hit;
    assign lane_hit              = host_wr && (idx == IDX_W'(i));
    assign mask_lane_we[i]       = lane_hit && (sel == SEL_MASK);
    assign clr_vec[i*8 +: 8]     = (lane_hit && (sel == SEL_CLEAR)) ? host_wdata : 8'h00;
  end

  // read mux: clear and unused select read zero
  always_comb begin
    host_rdata = 8'h00;
    for (int k = 0; k < NUM_BYTES; k++) begin
      if (idx == IDX_W'(k)) begin
        case (sel)
          SEL_EVENT: host_rdata = event_q[k*8 +: 8];
          SEL_MASK:  host_rdata = mask_q[k*8 +: 8];
          default:   host_rdata = 8'h00;
        endcase
      end
    end
  end
endmodule

// File: rtl/mie_mask_bank.sv
`timescale 1ns/1ps
module mie_mask_bank #(
  parameter int NUM_BYTES = 11,
  parameter int WIDTH     = NUM_BYTES * 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BYTES-1:0] lane_we,
  input  logic [7:0]           wdata,
  output logic [WIDTH-1:0]     mask_q
);
  function automatic logic [WIDTH-1:0] lanes_to_bits(input logic [NUM_BYTES-1:0] lanes);
    logic [WIDTH-1:0] r;
    for (int k = 0; k < NUM_BYTES; k++) r[k*8 +: 8] = {8{lanes[k]}};
    return r;
  endfunction

  logic [WIDTH-1:0] written_bits;
  assign written_bits = lanes_to_bits(lane_we);

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          mask_q[i*8 +: 8] <= 8'hFF;
      else if (lane_we[i]) mask_q[i*8 +: 8] <= wdata;
    end
  end

  // R9: bytes not written keep their value
  a_r9_untouched_bytes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(written_bits)) == '0));
endmodule

// File: rtl/mie_event_bank.sv
`timescale 1ns/1ps
module mie_event_bank #(
  parameter int WIDTH = 88
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_req,
  input  logic [WIDTH-1:0] mask_q,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] event_q
);
  // clear first, then OR in allowed sets: a set in the same cycle wins
  function automatic logic [WIDTH-1:0] next_event(
    input logic [WIDTH-1:0] cur, input logic [WIDTH-1:0] set,
    input logic [WIDTH-1:0] msk, input logic [WIDTH-1:0] clr);
    return (cur & ~clr) | (set & msk);
  endfunction

  logic [WIDTH-1:0] allowed_set;
  assign allowed_set = set_req & mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_q <= '0;
    else        event_q <= next_event(event_q, set_req, mask_q, clr_vec);
  end

  // R3: a bit may only rise where the mask was open
  a_r3_no_masked_rise: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_q & ~$past(event_q) & ~$past(mask_q)) == '0));
  // R4: cleared bits without a set request are zero afterwards
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((event_q & $past(clr_vec) & ~$past(set_req)) == '0));
  // R5: an allowed set is never lost, even against a clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(allowed_set) & ~event_q) == '0));
  // R6: set bits only fall through a clear (mask changes do not remove them)
  a_r6_only_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(event_q) & ~$past(clr_vec) & ~event_q) == '0));
endmodule

// File: rtl/masked_irq_event.sv
`timescale 1ns/1ps
module masked_irq_event
  import mie_pkg::*;
#(
  parameter int NUM_BYTES = 11,
  localparam int IDX_W    = $clog2(NUM_BYTES),
  localparam int WIDTH    = NUM_BYTES * 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WIDTH-1:0]       evt_set,
  input  logic                   host_wr,
  input  logic [SEL_W+IDX_W-1:0] host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  output logic                   irq_n
);
  logic [WIDTH-1:0]     event_q;
  logic [WIDTH-1:0]     mask_q;
  logic [WIDTH-1:0]     clr_vec;
  logic [NUM_BYTES-1:0] mask_lane_we;

  mie_host_port #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W), .WIDTH(WIDTH)) u_port (
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .event_q(event_q), .mask_q(mask_q), .mask_lane_we(mask_lane_we),
    .clr_vec(clr_vec), .host_rdata(host_rdata));

  mie_mask_bank #(.NUM_BYTES(NUM_BYTES), .WIDTH(WIDTH)) u_mask (
    .clk(clk), .rst_n(rst_n), .lane_we(mask_lane_we), .wdata(host_wdata),
    .mask_q(mask_q));

  mie_event_bank #(.WIDTH(WIDTH)) u_event (
    .clk(clk), .rst_n(rst_n), .set_req(evt_set), .mask_q(mask_q),
    .clr_vec(clr_vec), .event_q(event_q));

  assign irq_n = ~(|event_q);

  // R2: pin falls only after an allowed set request
  a_r2_fall_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> ($past(evt_set & mask_q) != '0));
  // R8: clear strobes only on a host write
  a_r8_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |-> host_wr);
endmodule

// File: tb/test_masked_irq_event.sv
`timescale 1ns/1ps
module test_masked_irq_event;
  localparam int NB = 11;
  localparam int W  = NB * 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt_set = '0;
  logic         host_wr = 1'b0;
  logic [5:0]   host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         irq_n;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  logic [W-1:0] exp_evt  = '0;
  logic [W-1:0] exp_mask = '1;

  masked_irq_event i_masked_irq_event (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_n(irq_n));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, host_addr, act, exp);
    end
  endtask

  // read every byte of every select, plus pin; called just after a falling edge
  task automatic check_all(input string tag);
    vectors++;
    if (irq_n !== (exp_evt == '0)) begin
      errors++;
      $display("FAIL R2 %s irq_n actual=%b expected=%b", tag, irq_n, exp_evt == '0);
    end
    for (int k = 0; k < 16; k++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0] e;
        string t;
        host_addr = {2'(s), 4'(k)};
        #0.1;
        e = 8'h00;
        t = tag;
        if (k >= NB || s == 3) t = "R10";
        else if (s == 2)       t = "R8";
        else if (s == 0)       e = exp_evt[k*8 +: 8];
        else                   e = exp_mask[k*8 +: 8];
        cmp(t, host_rdata, e);
      end
    end
  endtask

  task automatic step(input logic [W-1:0] set, input logic wr, input logic [1:0] sel,
                      input int idx, input logic [7:0] d);
    logic [W-1:0] clr;
    clr = '0;
    @(negedge clk);
    evt_set = set; host_wr = wr; host_addr = {sel, 4'(idx)}; host_wdata = d;
    if (wr && sel == 2'd2 && idx < NB) clr[idx*8 +: 8] = d;
    exp_evt = (exp_evt & ~clr) | (set & exp_mask);
    if (wr && sel == 2'd1 && idx < NB) exp_mask[idx*8 +: 8] = d;
    @(negedge clk);
    evt_set = '0; host_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R9: mask byte sweep, each checked against all others
    for (int i = 0; i < NB; i++) begin
      step('0, 1'b1, 2'd1, i, 8'hA5 ^ 8'(i * 17));
      check_all("R9");
    end
    // R10: out-of-range indices and unused select ignore writes
    for (int i = NB; i < 16; i++) begin
      step('0, 1'b1, 2'd1, i, 8'h00);
      step('0, 1'b1, 2'd2, i, 8'hFF);
      check_all("R10");
    end
    for (int i = 0; i < 16; i++) begin
      step('0, 1'b1, 2'd3, i, 8'h00);
    end
    check_all("R10");
    // R7: event register writes do nothing
    for (int i = 0; i < NB; i++) step('0, 1'b1, 2'd0, i, 8'hFF);
    check_all("R7");

    // R3: single-bit sets against mixed mask; R4: clear each back
    for (int b = 0; b < W; b++) begin
      step(W'(1) << b, 1'b0, 2'd0, 0, 8'h00);
      check_all("R3");
      step('0, 1'b1, 2'd2, b / 8, 8'(1) << (b % 8));
      check_all("R4");
    end

    // open mask fully, set everything, clear with patterns
    for (int i = 0; i < NB; i++) step('0, 1'b1, 2'd1, i, 8'hFF);
    step('1, 1'b0, 2'd0, 0, 8'h00);
    check_all("R3");
    for (int i = 0; i < NB; i++) begin
      step('0, 1'b1, 2'd2, i, 8'h3C ^ 8'(i));
      check_all("R4");
    end

    // R5: set all while clearing a full byte in the same cycle
    for (int i = 0; i < NB; i++) begin
      step('1, 1'b1, 2'd2, i, 8'hFF);
      check_all("R5");
    end

    // R6: closing the mask keeps existing events
    for (int i = 0; i < NB; i++) begin
      step('0, 1'b1, 2'd1, i, 8'h00);
      check_all("R6");
    end
    // sets now blocked (R3), same-cycle mask write + set on same byte (R9)
    for (int i = 0; i < NB; i++) begin
      step('0, 1'b1, 2'd2, i, 8'hFF);
    end
    step('1, 1'b0, 2'd0, 0, 8'h00);
    check_all("R3");
    step('1, 1'b1, 2'd1, 4, 8'h0F);
    check_all("R9");
    step('1, 1'b0, 2'd0, 0, 8'h00);
    check_all("R9");
    for (int i = 0; i < NB; i++) step('0, 1'b1, 2'd2, i, 8'hFF);
    check_all("R2");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule